// File: doc/BRIEF.md
# Read-Sequence Nonvolatile Command Detector

This block sits beside an SRAM-style bus and watches it for a hidden command. The bus is seen through a synchronous, sampled view: a 15-bit address, active-low chip enable, write enable and output enable, plus a clock and an active-low reset. The command is six reads in a row from fixed addresses. The sixth address decides whether the block asks its controller for a nonvolatile store or a nonvolatile recall. Because the unlock uses only reads, the surrounding memory keeps the pin behaviour of an ordinary SRAM.

Each access is counted once, in the sampled cycle where chip enable is first seen low. Any write, and any read from an address that does not fit, throws the attempt away. A read of the first key address after a mismatch starts a new attempt straight away. While the controller reports that a transfer is in progress, the block ignores the bus completely. Requests are one-clock pulses, and the step counter goes back to idle after every completed or aborted attempt.

Top module: `cmdseq_detect`

## Requirements
- R1: Reads of the 14-bit addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order, move the step counter from idle through five armed steps.
- R2: From the fifth armed step, a read of 0x0FC0 makes `store_req` high for exactly the clock after the edge that samples chip enable low for that read.
- R3: From the fifth armed step, a read of 0x0C63 makes `recall_req` high in the same cycle position that R2 gives for `store_req`.
- R4: Address bit 14 plays no part in matching. A sequence with bit 14 set gives the same request as one with it clear.
- R5: A sampled cycle with both chip enable and write enable low aborts the attempt to idle. This holds whether write enable is low at the chip-enable fall or goes low later in the same access.
- R6: A read of an address that does not fit the current step aborts the attempt. If that address is 0x0E38, the attempt restarts at the first armed step and is not thrown away.
- R7: Output enable has no effect on detection. Sequences complete the same way with it high, low or toggling.
- R8: A sequence whose sixth address is 0x339C gives neither request and leaves the detector idle.
- R9: At most one of `store_req` and `recall_req` is high in any cycle. Each is high for one cycle only, and the counter is idle after any request.
- R10: While `busy` is high, no request is produced and the counter is held at idle, even if `busy` rises in the cycle of the final read.
- R11: Each chip-enable low period counts as one access. Changing the address while chip enable stays low does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 15 | Sampled bus address; bits 13:0 are compared |
| ce_n | input | 1 | Sampled chip enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| oe_n | input | 1 | Sampled output enable, active low; not used for detection |
| busy | input | 1 | Controller reports a transfer in progress |
| store_req | output | 1 | One-cycle nonvolatile store request |
| recall_req | output | 1 | One-cycle nonvolatile recall request |

## Verification
Two events can fall in the same cycle:
- Completing the final matching read.
- Either of two blockers: a write strobe, or the controller's `busy` flag.

The bench forces both collisions at the exact sampled cycle of the sixth chip-enable fall:
- In one case, write enable is driven low together with chip enable.
- In the other, `busy` is raised on the same edge as chip enable.

The blocker must win in both cases, so neither request may appear. A later clean sequence must still fire, which shows the counter was left at idle and not stranded mid-sequence. A behavioural model updated on every clock judges each cycle, and directed pulse counts confirm the result of each scenario.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  localparam int CMP_W      = 14;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  localparam logic [CMP_W-1:0] STORE_KEY  = 14'h0FC0;
  localparam logic [CMP_W-1:0] RECALL_KEY = 14'h0C63;

  typedef logic [STEP_W-1:0] step_t;

  // prefix key for armed step idx (0 = first read)
  function automatic logic [CMP_W-1:0] prefix_key(input int idx);
    logic [CMP_W-1:0] k;
    case (idx)
      0:       k = 14'h0E38;
      1:       k = 14'h31C7;
      2:       k = 14'h03E0;
      3:       k = 14'h3C1F;
      default: k = 14'h303F;
    endcase
    return k;
  endfunction

  // step after an accepted read that is not a final hit
  function automatic step_t advance(input step_t cur, input logic hit_cur,
                                    input logic hit_first);
    step_t r;
    if (hit_cur)        r = cur + step_t'(1);
    else if (hit_first) r = step_t'(1);
    else                r = '0;
    return r;
  endfunction

endpackage

// File: rtl/cmdseq_strobe.sv
module cmdseq_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic acc_start,
  output logic wr_abort
);
  logic ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_n;
  end

  // read access: first sampled low cycle of chip enable, write enable high
  assign acc_start = ce_q & ~ce_n & we_n;
  // any sampled write strobe inside a selected cycle
  assign wr_abort  = ~ce_n & ~we_n;
endmodule

// File: rtl/cmdseq_match.sv
module cmdseq_match
  import cmdseq_pkg::*;
#(
  parameter int W   = CMP_W,
  parameter int NPF = PREFIX_LEN
) (
  input  logic [W-1:0] addr,
  input  step_t        step,
  output logic         hit_cur,
  output logic         hit_first,
  output logic         hit_store,
  output logic         hit_recall,
  output logic         at_final
);
  logic [NPF-1:0] hit_pf;
  logic [NPF-1:0] sel_pf;

  genvar gi;
  generate
    for (gi = 0; gi < NPF; gi++) begin : g_key
      assign hit_pf[gi] = (addr == W'(prefix_key(gi)));
      assign sel_pf[gi] = hit_pf[gi] & (step == step_t'(gi));
    end
  endgenerate

  assign hit_cur    = |sel_pf;
  assign hit_first  = hit_pf[0];
  assign at_final   = (step == step_t'(NPF));
  assign hit_store  = (addr == W'(STORE_KEY));
  assign hit_recall = (addr == W'(RECALL_KEY));
endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
  import cmdseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  busy,
  input  logic  acc_start,
  input  logic  wr_abort,
  input  logic  hit_cur,
  input  logic  hit_first,
  input  logic  hit_store,
  input  logic  hit_recall,
  input  logic  at_final,
  output step_t step_q,
  output logic  store_req,
  output logic  recall_req
);
  step_t step_d;
  logic  st_d, rc_d;

  always_comb begin
    step_d = step_q;
    st_d   = 1'b0;
    rc_d   = 1'b0;
    if (busy || wr_abort) begin
      step_d = '0;
    end else if (acc_start) begin
      if (at_final && hit_store) begin
        st_d   = 1'b1;
        step_d = '0;
      end else if (at_final && hit_recall) begin
        rc_d   = 1'b1;
        step_d = '0;
      end else begin
        step_d = advance(step_q, hit_cur, hit_first);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q     <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      step_q     <= step_d;
      store_req  <= st_d;
      recall_req <= rc_d;
    end
  end
endmodule

// File: rtl/cmdseq_detect.sv
module cmdseq_detect
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy,
  output logic              store_req,
  output logic              recall_req
);
  logic  acc_start, wr_abort;
  logic  hit_cur, hit_first, hit_store, hit_recall, at_final;
  step_t step_q;
  logic  unused_inputs;

  assign unused_inputs = ^{oe_n, bus_addr[ADDR_W-1:CMP_W]};

  cmdseq_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .acc_start(acc_start), .wr_abort(wr_abort)
  );

  cmdseq_match #(.W(CMP_W), .NPF(PREFIX_LEN)) u_match (
    .addr(bus_addr[CMP_W-1:0]), .step(step_q),
    .hit_cur(hit_cur), .hit_first(hit_first), .hit_store(hit_store),
    .hit_recall(hit_recall), .at_final(at_final)
  );

  cmdseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busy(busy), .acc_start(acc_start),
    .wr_abort(wr_abort), .hit_cur(hit_cur), .hit_first(hit_first),
    .hit_store(hit_store), .hit_recall(hit_recall), .at_final(at_final),
    .step_q(step_q), .store_req(store_req), .recall_req(recall_req)
  );
endmodule

// File: rtl/cmdseq_checker.sv
module cmdseq_checker
  import cmdseq_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  ce_n,
  input logic  we_n,
  input logic  busy,
  input logic  acc_start,
  input step_t step_q,
  input logic  store_req,
  input logic  recall_req
);
  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req); // R9
  AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req); // R9
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({store_req, recall_req}) <= 1); // R9
  AST_IDLE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> step_q == '0); // R9
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !store_req && !recall_req); // R10
  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> step_q == '0); // R10
  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> step_q == '0); // R5
  AST_REQ_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> $past(!ce_n && we_n)); // R2
  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= step_t'(PREFIX_LEN)); // R1
  AST_ADVANCE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(step_q) && step_q != '0) |-> $past(acc_start)); // R11
endmodule

bind cmdseq_detect cmdseq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .busy(busy),
  .acc_start(acc_start), .step_q(step_q),
  .store_req(store_req), .recall_req(recall_req)
);

// File: tb/sim_cmdseq_detect.sv
`timescale 1ns/1ps
module sim_cmdseq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] bus_addr = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic        store_req, recall_req;

  always #2 clk = ~clk;

  cmdseq_detect u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .busy(busy), .store_req(store_req), .recall_req(recall_req)
  );

  logic [13:0] keys[$] = '{14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F};
  int checks = 0, failures = 0, cyc = 0;
  int st_cnt = 0, rc_cnt = 0;
  bit done = 0;
  string phase = "R9";

  // behavioural reference
  int   ref_step = 0;
  bit   ref_ceq = 1;
  logic exp_st = 0, exp_rc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_step = 0; ref_ceq = 1; exp_st = 0; exp_rc = 0;
    end else begin
      exp_st = 0; exp_rc = 0;
      if (busy) ref_step = 0;
      else if (!ce_n && !we_n) ref_step = 0;
      else if (ref_ceq && !ce_n) begin
        if (ref_step == 5 && bus_addr[13:0] == 14'h0FC0) begin exp_st = 1; ref_step = 0; end
        else if (ref_step == 5 && bus_addr[13:0] == 14'h0C63) begin exp_rc = 1; ref_step = 0; end
        else if (ref_step < 5 && bus_addr[13:0] == keys[ref_step]) ref_step++;
        else ref_step = (bus_addr[13:0] == keys[0]) ? 1 : 0;
      end
      ref_ceq = ce_n;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(store_req === exp_st, {phase, " store_req per-cycle"}, store_req, exp_st);
      check(recall_req === exp_rc, {phase, " recall_req per-cycle"}, recall_req, exp_rc);
      if (store_req === 1'b1) st_cnt++;
      if (recall_req === 1'b1) rc_cnt++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic acc(input logic [14:0] a, input logic we, input logic oe);
    @(negedge clk); bus_addr = a; we_n = we; oe_n = oe; ce_n = 1'b0;
    @(negedge clk); oe_n = ~oe_n;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prefix(input logic b14, input logic oe);
    for (int i = 0; i < 5; i++) acc({b14, keys[i]}, 1'b1, oe);
  endtask

  task automatic expect_counts(input string tag, input int es, input int er);
    idle(3);
    check(st_cnt == es, {tag, " store count"}, st_cnt, es);
    check(rc_cnt == er, {tag, " recall count"}, rc_cnt, er);
    st_cnt = 0; rc_cnt = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(store_req === 1'b0 && recall_req === 1'b0, "R9 reset state", store_req, 0);

    phase = "R1"; prefix(0, 0); acc(15'h0FC0, 1, 0);
    expect_counts("R1 R2 store", 1, 0);

    phase = "R3"; prefix(0, 0); acc(15'h0C63, 1, 0);
    expect_counts("R3 recall", 0, 1);

    phase = "R4"; prefix(1, 0); acc(15'h4FC0, 1, 0);
    expect_counts("R4 bit14 ignored", 1, 0);

    phase = "R5";
    acc(15'h0E38, 1, 0); acc(15'h31C7, 1, 0); acc(15'h03E0, 0, 0);
    acc(15'h3C1F, 1, 0); acc(15'h303F, 1, 0); acc(15'h0FC0, 1, 0);
    expect_counts("R5 write at fall", 0, 0);
    acc(15'h0E38, 1, 0); acc(15'h31C7, 1, 0);
    @(negedge clk); bus_addr = 15'h03E0; ce_n = 0; we_n = 1;
    @(negedge clk); we_n = 0;
    @(negedge clk); we_n = 1; ce_n = 1;
    acc(15'h3C1F, 1, 0); acc(15'h303F, 1, 0); acc(15'h0FC0, 1, 0);
    expect_counts("R5 write mid-access", 0, 0);

    phase = "R6";
    acc(15'h0E38, 1, 0); acc(15'h31C7, 1, 0); acc(15'h03E0, 1, 0);
    acc(15'h1234, 1, 0); acc(15'h303F, 1, 0); acc(15'h0FC0, 1, 0);
    expect_counts("R6 stray read aborts", 0, 0);
    acc(15'h0E38, 1, 0); acc(15'h31C7, 1, 0); acc(15'h03E0, 1, 0);
    prefix(0, 0); acc(15'h0C63, 1, 0);
    expect_counts("R6 restart on first key", 0, 1);

    phase = "R7"; prefix(0, 1); acc(15'h0FC0, 1, 1);
    expect_counts("R7 oe high", 1, 0);

    phase = "R8"; prefix(0, 0); acc(15'h339C, 1, 0);
    expect_counts("R8 test sequence", 0, 0);
    acc(15'h0FC0, 1, 0);
    expect_counts("R8 idle after test sequence", 0, 0);

    phase = "R10"; busy = 1;
    acc(15'h0E38, 1, 0); acc(15'h31C7, 1, 0); acc(15'h03E0, 1, 0);
    busy = 0;
    acc(15'h3C1F, 1, 0); acc(15'h303F, 1, 0); acc(15'h0FC0, 1, 0);
    expect_counts("R10 busy holds idle", 0, 0);
    prefix(0, 0);
    @(negedge clk); bus_addr = 15'h0FC0; ce_n = 0; busy = 1;
    @(negedge clk); busy = 0;
    @(negedge clk); ce_n = 1;
    expect_counts("R10 busy on final read", 0, 0);
    phase = "R5"; prefix(0, 0); acc(15'h0FC0, 0, 0);
    expect_counts("R5 write on final read", 0, 0);
    phase = "R10"; prefix(0, 0); acc(15'h0FC0, 1, 0);
    expect_counts("R10 recovers after collision", 1, 0);

    phase = "R11";
    @(negedge clk); bus_addr = 15'h0E38; ce_n = 0;
    @(negedge clk); bus_addr = 15'h31C7;
    @(negedge clk); bus_addr = 15'h03E0;
    @(negedge clk); ce_n = 1;
    acc(15'h3C1F, 1, 0); acc(15'h303F, 1, 0); acc(15'h0FC0, 1, 0);
    expect_counts("R11 one count per enable", 0, 0);

    phase = "R9"; prefix(0, 0); acc(15'h0FC0, 1, 0);
    prefix(0, 0); acc(15'h0C63, 1, 0);
    expect_counts("R9 back-to-back", 1, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule